// File: doc/BRIEF.md
# Parity-Checked Reversible ALU

A combinational arithmetic logic unit of `WIDTH` bit slices, assembled only from gate models that keep the XOR of their inputs equal to the XOR of their outputs. Three gate kinds are used: a controlled-swap gate (three lines in and out) that serves as every 2:1 selector and as the addend generator, a double fan-out XOR gate (three lines), and a five-line full-adder gate with two inputs tied to zero. Each gate compares its input parity with its output parity, constant inputs and garbage outputs included. The OR of all those comparisons is the fault flag.

With the mode select high the block returns one of four bitwise functions of the operands. With it low the block adds operand A to a second addend built from B by the two low selects, plus carry-in, through a ripple chain. A one-hot injection vector can invert the working output line of any single gate, so that the flag can be exercised. Gate `k*9+g` is gate `g` of slice `k` (g = 0 addend generator, 1 full adder, 2 XOR/NOT fan-out, 3 AND, 4 OR, 5..7 logic selectors, 8 result selector). The last bit, `9*WIDTH`, is the carry-out gate.

Top module: `rev_alu`

## Requirements
- R1: With s_i[2]=0, {cout_o,f_o} equals A + Y + cin_i, where Y is chosen by s_i[1:0]: 00 all zeros, 01 B, 10 bitwise NOT B, 11 all ones.
- R2: The carry ripples through every slice: s_i=000 with cin_i=1 and A all ones gives f_o=0 and cout_o=1, and s_i=011 with cin_i=0 and A=0 gives f_o all ones and cout_o=0.
- R3: With s_i[2]=1, f_o is selected by s_i[1:0]: 00 A OR B, 01 A XOR B, 10 A AND B, 11 NOT A.
- R4: With s_i[2]=1, cin_i has no effect on f_o.
- R5: With s_i[2]=1, cout_o is 0.
- R6: With fault_inj_i all zeros, fault_o is 0 for every operand, select and carry-in value.
- R7: With exactly one bit of fault_inj_i set, fault_o is 1 for every operand, select and carry-in value.
- R8: Injecting bit k*9+8 inverts f_o[k] relative to the fault-free result, and injecting bit 9*WIDTH inverts cout_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| s_i | input | 3 | Select: bit 2 mode (1 = logic), bits 1:0 function |
| cin_i | input | 1 | Carry into slice 0 |
| fault_inj_i | input | 9*WIDTH+1 | One-hot gate output inversion |
| f_o | output | WIDTH | Result |
| cout_o | output | 1 | Carry out of the last slice, 0 in logic mode |
| fault_o | output | 1 | Some gate's input parity differs from its output parity |

## Verification
The bench builds the block with WIDTH=4, which puts every combination of both operands, all eight selects and both carry-in values within one exhaustive sweep of 4096 vectors, covering both ripple-through corners of R2. The same width yields 37 gate sites, so each one is injected singly under several operand and select patterns to show the flag rises whatever path the mode select routes to the outputs, and that the two result-side gates invert exactly the expected output bit.

// File: rtl/rev_alu_pkg.sv
package rev_alu_pkg;
  localparam int GPS = 9;  // gates per slice

  localparam int G_YGEN = 0;
  localparam int G_FA   = 1;
  localparam int G_XN   = 2;
  localparam int G_AND  = 3;
  localparam int G_OR   = 4;
  localparam int G_MLO  = 5;
  localparam int G_MHI  = 6;
  localparam int G_MLG  = 7;
  localparam int G_RES  = 8;

  function automatic int gate_count(input int width);
    return GPS * width + 1;
  endfunction
endpackage

// File: rtl/rev_fredkin.sv
// Controlled swap: p=c, q=c?y:x, r=c?x:y. USE_LINE picks the working output.
module rev_fredkin #(
  parameter int USE_LINE = 1
) (
  input  logic c_i,
  input  logic x_i,
  input  logic y_i,
  input  logic flip_i,
  output logic out_o,
  output logic err_o
);
  logic [2:0] line;

  always_comb begin
    line[0] = c_i;
    line[1] = c_i ? y_i : x_i;
    line[2] = c_i ? x_i : y_i;
    line[USE_LINE] = line[USE_LINE] ^ flip_i;
  end

  assign out_o = line[USE_LINE];
  assign err_o = (c_i ^ x_i ^ y_i) ^ (^line);
endmodule

// File: rtl/rev_dfg.sv
// Double fan-out XOR: p=a, q=a^b, r=a^c. Injection hits q.
module rev_dfg (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  input  logic flip_i,
  output logic q_o,
  output logic r_o,
  output logic err_o
);
  logic [2:0] line;

  always_comb begin
    line[0] = a_i;
    line[1] = (a_i ^ b_i) ^ flip_i;
    line[2] = a_i ^ c_i;
  end

  assign q_o   = line[1];
  assign r_o   = line[2];
  assign err_o = (a_i ^ b_i ^ c_i) ^ (^line);
endmodule

// File: rtl/rev_fa5.sv
// Five-line full adder; z inputs are tied low, three garbage outputs.
module rev_fa5 (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  input  logic z0_i,
  input  logic z1_i,
  input  logic flip_i,
  output logic sum_o,
  output logic cy_o,
  output logic err_o
);
  logic       maj;
  logic [2:0] garbage;
  logic [4:0] line;

  assign maj = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);

  always_comb begin
    garbage[0] = a_i;
    garbage[1] = b_i;
    garbage[2] = maj ^ a_i ^ b_i;  // balances output parity
    line = {maj, (a_i ^ b_i ^ c_i) ^ flip_i, garbage};
  end

  assign sum_o = line[3];
  assign cy_o  = line[4];
  assign err_o = (a_i ^ b_i ^ c_i ^ z0_i ^ z1_i) ^ (^line);
endmodule

// File: rtl/rev_alu_slice.sv
module rev_alu_slice
  import rev_alu_pkg::*;
(
  input  logic           a_i,
  input  logic           b_i,
  input  logic [2:0]     s_i,
  input  logic           c_i,
  input  logic [GPS-1:0] inj_i,
  output logic           f_o,
  output logic           c_o,
  output logic [GPS-1:0] err_o
);
  logic y, sum, x_ab, n_a, and_ab, or_ab, lo, hi, lg;

  // Y = B ? S0 : S1 -> 00:0, 01:B, 10:~B, 11:1
  rev_fredkin #(.USE_LINE(1)) u_ygen (
    .c_i(b_i), .x_i(s_i[1]), .y_i(s_i[0]), .flip_i(inj_i[G_YGEN]),
    .out_o(y), .err_o(err_o[G_YGEN])
  );

  rev_fa5 u_fa (
    .a_i(a_i), .b_i(y), .c_i(c_i), .z0_i(1'b0), .z1_i(1'b0),
    .flip_i(inj_i[G_FA]), .sum_o(sum), .cy_o(c_o), .err_o(err_o[G_FA])
  );

  rev_dfg u_xn (
    .a_i(a_i), .b_i(b_i), .c_i(1'b1), .flip_i(inj_i[G_XN]),
    .q_o(x_ab), .r_o(n_a), .err_o(err_o[G_XN])
  );

  rev_fredkin #(.USE_LINE(2)) u_and (
    .c_i(a_i), .x_i(b_i), .y_i(1'b0), .flip_i(inj_i[G_AND]),
    .out_o(and_ab), .err_o(err_o[G_AND])
  );

  rev_fredkin #(.USE_LINE(1)) u_or (
    .c_i(a_i), .x_i(b_i), .y_i(1'b1), .flip_i(inj_i[G_OR]),
    .out_o(or_ab), .err_o(err_o[G_OR])
  );

  rev_fredkin #(.USE_LINE(1)) u_mlo (
    .c_i(s_i[0]), .x_i(or_ab), .y_i(x_ab), .flip_i(inj_i[G_MLO]),
    .out_o(lo), .err_o(err_o[G_MLO])
  );

  rev_fredkin #(.USE_LINE(1)) u_mhi (
    .c_i(s_i[0]), .x_i(and_ab), .y_i(n_a), .flip_i(inj_i[G_MHI]),
    .out_o(hi), .err_o(err_o[G_MHI])
  );

  rev_fredkin #(.USE_LINE(1)) u_mlg (
    .c_i(s_i[1]), .x_i(lo), .y_i(hi), .flip_i(inj_i[G_MLG]),
    .out_o(lg), .err_o(err_o[G_MLG])
  );

  rev_fredkin #(.USE_LINE(1)) u_res (
    .c_i(s_i[2]), .x_i(sum), .y_i(lg), .flip_i(inj_i[G_RES]),
    .out_o(f_o), .err_o(err_o[G_RES])
  );
endmodule

// File: rtl/rev_alu.sv
module rev_alu
  import rev_alu_pkg::*;
#(
  parameter int WIDTH = 4,
  localparam int NG   = GPS * WIDTH + 1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       s_i,
  input  logic             cin_i,
  input  logic [NG-1:0]    fault_inj_i,
  output logic [WIDTH-1:0] f_o,
  output logic             cout_o,
  output logic             fault_o
);
  logic [WIDTH:0]  carry;
  logic [NG-1:0]   err;

  assign carry[0] = cin_i;

  for (genvar k = 0; k < WIDTH; k++) begin : g_slice
    rev_alu_slice u_slice (
      .a_i(a_i[k]), .b_i(b_i[k]), .s_i(s_i), .c_i(carry[k]),
      .inj_i(fault_inj_i[k*GPS +: GPS]),
      .f_o(f_o[k]), .c_o(carry[k+1]),
      .err_o(err[k*GPS +: GPS])
    );
  end

  // logic mode forces carry-out low
  rev_fredkin #(.USE_LINE(1)) u_cout (
    .c_i(s_i[2]), .x_i(carry[WIDTH]), .y_i(1'b0), .flip_i(fault_inj_i[NG-1]),
    .out_o(cout_o), .err_o(err[NG-1])
  );

  assign fault_o = |err;
endmodule

// File: rtl/rev_alu_chk.sv
module rev_alu_chk
  import rev_alu_pkg::*;
#(
  parameter int WIDTH = 4,
  localparam int NG   = GPS * WIDTH + 1
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       s_i,
  input logic             cin_i,
  input logic [NG-1:0]    fault_inj_i,
  input logic [WIDTH-1:0] f_o,
  input logic             cout_o,
  input logic             fault_o
);
  logic [WIDTH-1:0] y_ref, l_ref;
  logic [WIDTH:0]   s_ref;

  always_comb begin
    case (s_i[1:0])
      2'b00:   y_ref = '0;
      2'b01:   y_ref = b_i;
      2'b10:   y_ref = ~b_i;
      default: y_ref = '1;
    endcase
    case (s_i[1:0])
      2'b00:   l_ref = a_i | b_i;
      2'b01:   l_ref = a_i ^ b_i;
      2'b10:   l_ref = a_i & b_i;
      default: l_ref = ~a_i;
    endcase
    s_ref = {1'b0, a_i} + {1'b0, y_ref} + {{WIDTH{1'b0}}, cin_i};
  end

  always_comb begin
    if (fault_inj_i == '0 && !s_i[2])
      AST_ARITH_SUM: assert ({cout_o, f_o} == s_ref); // R1
    if (fault_inj_i == '0 && s_i[2])
      AST_LOGIC_RES: assert (f_o == l_ref); // R3
    if (fault_inj_i == '0 && s_i[2])
      AST_LOGIC_COUT_LOW: assert (!cout_o); // R5
    if (fault_inj_i == '0)
      AST_NO_FALSE_FLAG: assert (!fault_o); // R6
    if ($onehot(fault_inj_i))
      AST_FLAG_ON_FLIP: assert (fault_o); // R7
  end
endmodule

bind rev_alu rev_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_rev_alu.sv
`timescale 1ns/1ps
module tb_rev_alu;
  localparam int W  = 4;
  localparam int NG = 9 * W + 1;
  localparam int MX = (1 << W) - 1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [W-1:0]  a, b, f;
  logic [2:0]    s;
  logic          cin, cout, flt;
  logic [NG-1:0] inj;
  int            errors = 0;
  int            checks = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  rev_alu #(.WIDTH(W)) dut (
    .a_i(a), .b_i(b), .s_i(s), .cin_i(cin), .fault_inj_i(inj),
    .f_o(f), .cout_o(cout), .fault_o(flt)
  );

  function automatic int ref_calc(input int av, input int bv, input int sv, input int cv);
    int y;
    if (sv >= 4) begin
      case (sv & 3)
        0: return (av | bv) & MX;
        1: return (av ^ bv) & MX;
        2: return (av & bv) & MX;
        default: return (~av) & MX;
      endcase
    end
    case (sv & 3)
      0: y = 0;
      1: y = bv;
      2: y = (~bv) & MX;
      default: y = MX;
    endcase
    return av + y + cv;  // bit W is the carry
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (a=%0h b=%0h s=%0d cin=%0d)",
               req, act, exp, a, b, s, cin);
    end
  endtask

  task automatic drive(input int av, input int bv, input int sv, input int cv,
                       input logic [NG-1:0] iv);
    @(posedge clk);
    a = W'(av); b = W'(bv); s = 3'(sv); cin = cv[0]; inj = iv;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    a = '0; b = '0; s = '0; cin = 1'b0; inj = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R6 idle flag", int'(flt), 0);
    chk("R1 idle result", int'({cout, f}), 0);

    // exhaustive fault-free sweep
    for (int sv = 0; sv < 8; sv++)
      for (int cv = 0; cv < 2; cv++)
        for (int av = 0; av <= MX; av++)
          for (int bv = 0; bv <= MX; bv++) begin
            int e;
            drive(av, bv, sv, cv, '0);
            e = ref_calc(av, bv, sv, cv);
            if (sv < 4) begin
              if ((sv == 0 && cv == 1 && av == MX) || (sv == 3 && cv == 0 && av == 0))
                chk("R2 ripple corner", int'({cout, f}), e);
              else
                chk("R1 arith", int'({cout, f}), e);
            end else begin
              chk(cv ? "R4 logic cin=1" : "R3 logic", int'(f), e);
              chk("R5 logic cout", int'(cout), 0);
            end
            chk("R6 no fault", int'(flt), 0);
          end

    // single-fault sweep
    for (int g = 0; g < NG; g++)
      for (int v = 0; v < 8; v++) begin
        int av, bv, cv, e;
        logic [NG-1:0] iv;
        av = (v * 5 + g) & MX;
        bv = (v * 3 + 2 * g + 1) & MX;
        cv = (v + g) & 1;
        iv = '0;
        iv[g] = 1'b1;
        drive(av, bv, v, cv, iv);
        e = ref_calc(av, bv, v, cv);
        if (v >= 4) e = e & MX;
        chk("R7 flag on flip", int'(flt), 1);
        if (g == NG - 1)
          chk("R8 cout flip", int'(cout), ((e >> W) & 1) ^ 1);
        else if (g % 9 == 8)
          chk("R8 result bit flip", int'(f), (e & MX) ^ (1 << (g / 9)));
      end

    drive(0, 0, 0, 0, '0);
    chk("R6 after faults", int'(flt), 0);
    done = 1'b1;
    summary();
  end
endmodule